// File: doc/BRIEF.md
# Descriptor Ring Pointer Sequencer

This block walks two descriptor rings in system memory, one for received frames and one for frames to transmit, on behalf of a bus-mastering serial controller. Both rings share one 1 KiB-aligned region. The receive ring takes the lower half and the transmit ring the upper half. Each descriptor is two 32-bit words. The first word carries a 12-bit byte count. The second carries a 24-bit buffer pointer, with a status byte in its top eight bits. Bit 7 of that status byte marks a descriptor as handed to the hardware.

A single strobe from software starts any ring that is idle. The ring reads the descriptor at its current index. If the handover bit is set, the ring presents the buffer address and length to the datapath and holds the descriptor until the datapath reports the frame finished. It then writes back the final count and a status byte with the handover bit cleared and the error flags merged in. The index then steps forward, wrapping at the programmed ring size, and the ring fetches the next descriptor at once. All memory traffic goes through one single-word request/acknowledge port, which serves both rings in turn. A combined read-back vector exposes both indices.

Top module: `dring_sequencer`

## Requirements
- R1: The ring-size register takes a 4-bit code for each ring, transmit in bits [15:12] and receive in bits [11:8]. The codes 0000, 0001, 0011, 0111 and 1111 select 4, 8, 16, 32 and 64 descriptors. Any other code acts as the size given by its unbroken run of ones counted from bit 0 (0010 gives 4, 0101 gives 8).
- R2: A descriptor word address is the 8-bit page in [31:24], the 14-bit base in [23:10], the ring bit in [9] (1 for transmit), the index in [8:3], and the word select in [2], with [1:0] zero. The count word is at +0 and the pointer/status word at +4.
- R3: A prompt (a write of any value to selector 3) makes an idle ring read its count word and then its pointer/status word. If bit 31 of the second word is set, the ring owns the descriptor and presents buffer address {page, word1[23:0]} and length word0[11:0].
- R4: A prompt has no effect on a ring that is busy or owns a descriptor. Its index, buffer outputs and memory traffic stay unchanged.
- R5: A fetched descriptor whose bit 31 is clear returns the ring to idle without changing its index.
- R6: A done pulse while the ring owns a descriptor writes the count word as the 12-bit reported count, zero-extended. It then writes the pointer/status word as {(status & 0x7F) | error[6:0], pointer}. The index then increments modulo the ring size, and the ring fetches the next descriptor immediately.
- R7: A done pulse to a ring that does not own a descriptor is ignored.
- R8: The pointer read-back holds the receive index in [5:0] and the transmit index in [13:8]. All other bits read zero.
- R9: While master enable is low, both rings are idle with index 0, any pending memory request is withdrawn, and prompts are ignored.
- R10: The memory port carries one access at a time. The request holds address, write-enable and data stable until acknowledged. Each ring makes exactly two reads per fetch and two writes per close.
- R11: After reset both indices are 0, no ring owns a descriptor and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_en | input | 1 | Master enable; low stops and rewinds both rings |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 base, 1 ring sizes, 2 page, 3 prompt |
| cfg_wdata | input | 16 | Configuration write data |
| ptr_rd | output | 16 | Combined ring index read-back |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address (byte address) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| rx_own | output | 1 | Receive ring holds a live descriptor |
| rx_buf_addr | output | 32 | Receive buffer address |
| rx_buf_len | output | 12 | Receive buffer length |
| rx_buf_status | output | 8 | Receive descriptor status byte |
| rx_done | input | 1 | Receive frame finished |
| rx_done_cnt | input | 12 | Receive byte count to write back |
| rx_done_err | input | 7 | Receive error flags to merge |
| tx_own | output | 1 | Transmit ring holds a live descriptor |
| tx_buf_addr | output | 32 | Transmit buffer address |
| tx_buf_len | output | 12 | Transmit buffer length |
| tx_buf_status | output | 8 | Transmit descriptor status byte |
| tx_done | input | 1 | Transmit frame finished |
| tx_done_cnt | input | 12 | Transmit byte count to write back |
| tx_done_err | input | 7 | Transmit error flags to merge |

## Verification
The hardest case to reach is the index wrap followed by a fetch of a descriptor the ring itself has just closed. That needs every slot of a ring to be consumed while the other ring competes for the memory port. The stimulus arms all 64 slots of both rings, sweeps six size-code pairs (including two non-thermometer codes), and drives both rings frame by frame with memory latencies of 0 to 2 cycles. The ring must then stop at index 0 without touching the slots beyond its size. A closed descriptor is re-armed afterwards to confirm that a prompt restarts the ring. The exact access count per sweep shows that no prompt or stray done produced extra traffic.

// File: rtl/dring_pkg.sv
// Shared types and constants for the descriptor ring sequencer.
// Assumes a 24-bit in-page address space and 32-bit memory words.
package dring_pkg;

    typedef enum logic [2:0] {
        RS_IDLE   = 3'd0,
        RS_RD_CNT = 3'd1,
        RS_RD_ST  = 3'd2,
        RS_OWN    = 3'd3,
        RS_WR_CNT = 3'd4,
        RS_WR_ST  = 3'd5
    } ring_state_t;

    localparam int          PAGE_W  = 8;
    localparam int          LOW_W   = 24;
    localparam int          ERR_W   = 7;
    localparam logic [1:0]  SEL_BASE = 2'd0;
    localparam logic [1:0]  SEL_SIZE = 2'd1;
    localparam logic [1:0]  SEL_PAGE = 2'd2;
    localparam logic [1:0]  SEL_KICK = 2'd3;

endpackage

// File: rtl/dring_size_dec.sv
// Turns a thermometer ring-size code into an index wrap mask.
// Assumes two always-present low index bits (minimum ring of 4).
// A broken code counts only the run of ones starting at bit 0.
module dring_size_dec #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-3:0] code,
    output logic [IDX_W-1:0] wrap_mask
);
    localparam int CODE_W = IDX_W - 2;

    assign wrap_mask[1:0] = 2'b11;

    // One mask bit per code bit: set only while all lower code bits are set
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        assign wrap_mask[i+2] = &code[i:0];
    end
endmodule

// File: rtl/dring_ring.sv
// Per-direction descriptor ring walker.
// Fetches count and pointer/status words, holds a live descriptor until
// the datapath reports completion, writes both words back and advances.
// Assumes its memory acknowledge is already qualified for this ring.
module dring_ring
    import dring_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 12,
    parameter bit IS_TX  = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mst_en,
    input  logic                  kick,
    input  logic [LOW_W-IDX_W-5:0] base,
    input  logic [PAGE_W-1:0]     page,
    input  logic [IDX_W-1:0]      wrap_mask,
    input  logic                  ack,
    input  logic [31:0]           rdata,
    input  logic                  done,
    input  logic [CNT_W-1:0]      done_cnt,
    input  logic [ERR_W-1:0]      done_err,
    output logic                  req,
    output logic                  we,
    output logic [31:0]           addr,
    output logic [31:0]           wdata,
    output logic [IDX_W-1:0]      idx,
    output logic                  own,
    output logic [31:0]           buf_addr,
    output logic [CNT_W-1:0]      buf_len,
    output logic [7:0]            buf_status
);
    localparam logic DIR_BIT = IS_TX ? 1'b1 : 1'b0;

    ring_state_t        state;
    logic [CNT_W-1:0]   cnt_q;
    logic [LOW_W-1:0]   ptr_q;
    logic [7:0]         stat_q;
    logic               word_sel;
    logic [IDX_W-1:0]   idx_next;

    assign idx_next = (idx + IDX_W'(1)) & wrap_mask;

    // Ring sequencing and index; master disable rewinds everything
    always_ff @(posedge clk) begin
        if (!rst_n || !mst_en) begin
            state <= RS_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                RS_IDLE:   if (kick) state <= RS_RD_CNT;
                RS_RD_CNT: if (ack)  state <= RS_RD_ST;
                RS_RD_ST:  if (ack)  state <= rdata[31] ? RS_OWN : RS_IDLE;
                RS_OWN:    if (done) state <= RS_WR_CNT;
                RS_WR_CNT: if (ack)  state <= RS_WR_ST;
                RS_WR_ST:  if (ack) begin
                    state <= RS_RD_CNT;
                    idx   <= idx_next;
                end
                default:   state <= RS_IDLE;
            endcase
        end
    end

    // Descriptor contents captured on fetch and updated on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ptr_q  <= '0;
            stat_q <= '0;
        end else begin
            if (state == RS_RD_CNT && ack) begin
                cnt_q <= rdata[CNT_W-1:0];
            end
            if (state == RS_RD_ST && ack) begin
                ptr_q  <= rdata[LOW_W-1:0];
                stat_q <= rdata[31:24];
            end
            if (state == RS_OWN && done) begin
                cnt_q  <= done_cnt;
                stat_q <= (stat_q & 8'h7F) | {1'b0, done_err};
            end
        end
    end

    assign req      = (state == RS_RD_CNT) || (state == RS_RD_ST) ||
                      (state == RS_WR_CNT) || (state == RS_WR_ST);
    assign we       = (state == RS_WR_CNT) || (state == RS_WR_ST);
    assign word_sel = (state == RS_RD_ST)  || (state == RS_WR_ST);
    assign addr     = {page, base, DIR_BIT, idx, word_sel, 2'b00};

    // Write-back word for the current close step
    always_comb begin
        unique case (state)
            RS_WR_CNT: wdata = {{(32-CNT_W){1'b0}}, cnt_q};
            RS_WR_ST:  wdata = {stat_q, ptr_q};
            default:   wdata = '0;
        endcase
    end

    assign own        = (state == RS_OWN);
    assign buf_addr   = {page, ptr_q};
    assign buf_len    = cnt_q;
    assign buf_status = stat_q;
endmodule

// File: rtl/dring_arb.sv
// Round-robin owner of the single memory port.
// Latches one requester, keeps it until acknowledge, then rotates.
// Assumes requesters hold their request and payload until acknowledged.
module dring_arb #(
    parameter int N = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mst_en,
    input  logic [N-1:0]         req,
    input  logic                 mem_ack,
    output logic                 busy,
    output logic [SEL_W-1:0]     sel,
    output logic [N-1:0]         ack_vec
);
    localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

    logic [SEL_W-1:0] last;
    logic [SEL_W-1:0] pick;
    logic             found;

    // Search starting one past the last served requester
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(last) + k) % N;
            if (!found && req[cand]) begin
                found = 1'b1;
                pick  = SEL_W'(cand);
            end
        end
    end

    // Grant holding; disable withdraws the pending access
    always_ff @(posedge clk) begin
        if (!rst_n || !mst_en) begin
            busy <= 1'b0;
            sel  <= '0;
            last <= SEL_W'(N - 1);
        end else if (busy) begin
            if (mem_ack) busy <= 1'b0;
        end else if (found) begin
            busy <= 1'b1;
            sel  <= pick;
            last <= pick;
        end
    end

    // Route the acknowledge to the granted requester only
    for (genvar i = 0; i < N; i++) begin : g_ack
        assign ack_vec[i] = busy && mem_ack && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/dring_sequencer.sv
// Top of the descriptor ring sequencer: configuration registers,
// two ring walkers sharing one memory port, and index read-back.
// Assumes at most 64 descriptors per ring (size codes of 4 bits).
module dring_sequencer
    import dring_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_en,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       ptr_rd,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              rx_own,
    output logic [31:0]       rx_buf_addr,
    output logic [CNT_W-1:0]  rx_buf_len,
    output logic [7:0]        rx_buf_status,
    input  logic              rx_done,
    input  logic [CNT_W-1:0]  rx_done_cnt,
    input  logic [ERR_W-1:0]  rx_done_err,
    output logic              tx_own,
    output logic [31:0]       tx_buf_addr,
    output logic [CNT_W-1:0]  tx_buf_len,
    output logic [7:0]        tx_buf_status,
    input  logic              tx_done,
    input  logic [CNT_W-1:0]  tx_done_cnt,
    input  logic [ERR_W-1:0]  tx_done_err
);
    localparam int CODE_W = IDX_W - 2;
    localparam int BASE_W = LOW_W - IDX_W - 4;
    localparam int NRING  = 2;

    logic [BASE_W-1:0]  base_q;
    logic [PAGE_W-1:0]  page_q;
    logic [CODE_W-1:0]  code_q   [NRING];
    logic [IDX_W-1:0]   mask_w   [NRING];
    logic               kick;

    logic [NRING-1:0]   r_req;
    logic [NRING-1:0]   r_we;
    logic [NRING-1:0]   r_ack;
    logic [NRING-1:0]   r_own;
    logic [31:0]        r_addr   [NRING];
    logic [31:0]        r_wdata  [NRING];
    logic [IDX_W-1:0]   r_idx    [NRING];
    logic [31:0]        r_baddr  [NRING];
    logic [CNT_W-1:0]   r_blen   [NRING];
    logic [7:0]         r_bstat  [NRING];
    logic [NRING-1:0]   d_done;
    logic [CNT_W-1:0]   d_cnt    [NRING];
    logic [ERR_W-1:0]   d_err    [NRING];
    logic               arb_busy;
    logic [0:0]         arb_sel;

    // Configuration registers, writable whatever the enable state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            page_q    <= '0;
            code_q[0] <= '0;
            code_q[1] <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_BASE) base_q <= cfg_wdata[BASE_W-1:0];
            if (cfg_sel == SEL_PAGE) page_q <= cfg_wdata[PAGE_W-1:0];
            if (cfg_sel == SEL_SIZE) begin
                code_q[0] <= cfg_wdata[8 +: CODE_W];
                code_q[1] <= cfg_wdata[12 +: CODE_W];
            end
        end
    end

    assign kick = cfg_we && (cfg_sel == SEL_KICK);

    assign d_done   = {tx_done, rx_done};
    assign d_cnt[0] = rx_done_cnt;
    assign d_cnt[1] = tx_done_cnt;
    assign d_err[0] = rx_done_err;
    assign d_err[1] = tx_done_err;

    // One size decoder and one walker per direction (0 receive, 1 transmit)
    for (genvar g = 0; g < NRING; g++) begin : g_ring
        dring_size_dec #(.IDX_W(IDX_W)) u_dec (
            .code      (code_q[g]),
            .wrap_mask (mask_w[g])
        );

        dring_ring #(
            .IDX_W (IDX_W),
            .CNT_W (CNT_W),
            .IS_TX (g == 1)
        ) u_ring (
            .clk        (clk),
            .rst_n      (rst_n),
            .mst_en     (mst_en),
            .kick       (kick),
            .base       (base_q),
            .page       (page_q),
            .wrap_mask  (mask_w[g]),
            .ack        (r_ack[g]),
            .rdata      (mem_rdata),
            .done       (d_done[g]),
            .done_cnt   (d_cnt[g]),
            .done_err   (d_err[g]),
            .req        (r_req[g]),
            .we         (r_we[g]),
            .addr       (r_addr[g]),
            .wdata      (r_wdata[g]),
            .idx        (r_idx[g]),
            .own        (r_own[g]),
            .buf_addr   (r_baddr[g]),
            .buf_len    (r_blen[g]),
            .buf_status (r_bstat[g])
        );
    end

    dring_arb #(.N(NRING)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .mst_en  (mst_en),
        .req     (r_req),
        .mem_ack (mem_ack),
        .busy    (arb_busy),
        .sel     (arb_sel),
        .ack_vec (r_ack)
    );

    assign mem_req   = arb_busy;
    assign mem_we    = r_we[arb_sel];
    assign mem_addr  = r_addr[arb_sel];
    assign mem_wdata = r_wdata[arb_sel];

    // Index read-back: receive at the bottom, transmit from bit 8
    always_comb begin
        ptr_rd = '0;
        ptr_rd[IDX_W-1:0]  = r_idx[0];
        ptr_rd[8 +: IDX_W] = r_idx[1];
    end

    assign rx_own        = r_own[0];
    assign rx_buf_addr   = r_baddr[0];
    assign rx_buf_len    = r_blen[0];
    assign rx_buf_status = r_bstat[0];
    assign tx_own        = r_own[1];
    assign tx_buf_addr   = r_baddr[1];
    assign tx_buf_len    = r_blen[1];
    assign tx_buf_status = r_bstat[1];
endmodule

// File: rtl/dring_sequencer_chk.sv
// Port-level protocol checks for the descriptor ring sequencer.
// Assumes it is bound to every instance of the top module.
module dring_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mst_en,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        rx_own,
    input logic        tx_own,
    input logic [15:0] ptr_rd
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n || !mst_en)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !mst_en |=> !mem_req && !rx_own && !tx_own && (ptr_rd == 16'h0000)); // R9

    AST_RX_OWN_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_own) |-> $past(mem_ack) && !$past(mem_we)); // R3

    AST_TX_OWN_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_own) |-> $past(mem_ack) && !$past(mem_we)); // R3

    AST_IDX_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mst_en) && !$stable(ptr_rd) |-> $past(mem_ack) && $past(mem_we)); // R6
endmodule

bind dring_sequencer dring_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mst_en    (mst_en),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rx_own    (rx_own),
    .tx_own    (tx_own),
    .ptr_rd    (ptr_rd)
);

// File: tb/test_dring_sequencer.sv
`timescale 1ns/1ps
module test_dring_sequencer;
    logic        clk = 1'b0;
    logic        rst_n, mst_en, cfg_we;
    logic [1:0]  cfg_sel;
    logic [15:0] cfg_wdata, ptr_rd;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        rx_own, tx_own, rx_done, tx_done;
    logic [31:0] rx_buf_addr, tx_buf_addr;
    logic [11:0] rx_buf_len, tx_buf_len, rx_done_cnt, tx_done_cnt;
    logic [7:0]  rx_buf_status, tx_buf_status;
    logic [6:0]  rx_done_err, tx_done_err;

    logic [31:0] mem [0:255];
    int          checks = 0, errors = 0, acc_cnt = 0, lat = 0;
    logic [7:0]  tb_page = '0;
    logic [13:0] tb_base = '0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    dring_sequencer i_dring_sequencer (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] e_len(int d, int k, int sw);
        return 12'(100 + 37 * k + 700 * d + 3 * sw);
    endfunction
    function automatic logic [23:0] e_ptr(int d, int k, int sw);
        return 24'(32'h010000 + d * 32'h8000 + k * 32'h100 + sw);
    endfunction
    function automatic logic [7:0] e_stat(int d, int k);
        return 8'h80 | 8'((k * 3 + d * 17) & 32'h7F);
    endfunction
    function automatic logic [6:0] e_err(int d, int k, int sw);
        return 7'((k * 11 + d * 5 + sw) & 32'h7F);
    endfunction
    function automatic logic [11:0] e_dcnt(int d, int k, int sw);
        return e_len(d, k, sw) ^ 12'h5A5;
    endfunction
    function automatic int size_of(logic [3:0] code);
        int run = 0;
        for (int i = 0; i < 4; i++) if (code[i] && run == i) run++;
        return 4 << run;
    endfunction
    function automatic int slot(int d, int k);
        return d * 128 + 2 * k;
    endfunction

    // Memory model: single-word, optional latency, checks page and base
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                logic [31:0] a;
                a = mem_addr;
                if (lat > 0) begin
                    repeat (lat) @(negedge clk);
                    chk("R10 request held", {mem_addr[31:1], mem_req}, {a[31:1], 1'b1});
                end
                chk("R2 page/base", {10'b0, mem_addr[31:10]}, {10'b0, tb_page, tb_base});
                if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[9:2]];
                mem_ack = 1'b1;
                acc_cnt++;
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic own_of(int d);
        return (d == 1) ? tx_own : rx_own;
    endfunction

    task automatic wait_own(int d);
        for (int t = 0; t < 400; t++) begin
            if (own_of(d)) break;
            @(negedge clk);
        end
    endtask

    // Serve one live descriptor of ring d at index k
    task automatic service(int d, int k, int sw);
        logic [5:0] fld;
        wait_own(d);
        chk("R3 ring owns descriptor", {31'b0, own_of(d)}, 32'd1);
        fld = (d == 1) ? ptr_rd[13:8] : ptr_rd[5:0];
        chk("R8 index field", {26'b0, fld}, 32'(k));
        chk("R3 buffer length", {20'b0, (d == 1) ? tx_buf_len : rx_buf_len}, {20'b0, e_len(d, k, sw)});
        chk("R2 buffer address", (d == 1) ? tx_buf_addr : rx_buf_addr, {tb_page, e_ptr(d, k, sw)});
        if (d == 0 && k == 1) begin
            cfg_write(2'd3, 16'hFFFF);
            repeat (5) @(negedge clk);
            chk("R4 prompt ignored: own", {31'b0, rx_own}, 32'd1);
            chk("R4 prompt ignored: index", {26'b0, ptr_rd[5:0]}, 32'd1);
            chk("R4 prompt ignored: length", {20'b0, rx_buf_len}, {20'b0, e_len(0, 1, sw)});
        end
        @(negedge clk);
        if (d == 1) begin
            tx_done = 1'b1; tx_done_cnt = e_dcnt(d, k, sw); tx_done_err = e_err(d, k, sw);
        end else begin
            rx_done = 1'b1; rx_done_cnt = e_dcnt(d, k, sw); rx_done_err = e_err(d, k, sw);
        end
        @(negedge clk);
        rx_done = 1'b0; tx_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] rxc [6];
        logic [3:0] txc [6];
        rxc = '{4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111, 4'b0010};
        txc = '{4'b1111, 4'b0111, 4'b0011, 4'b0001, 4'b0000, 4'b0101};
        rst_n = 1'b0; mst_en = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        rx_done = 1'b0; tx_done = 1'b0; rx_done_cnt = '0; tx_done_cnt = '0;
        rx_done_err = '0; tx_done_err = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset index", {16'b0, ptr_rd}, 32'd0);
        chk("R11 reset request", {31'b0, mem_req}, 32'd0);
        chk("R11 reset own", {30'b0, rx_own, tx_own}, 32'd0);

        for (int sw = 0; sw < 6; sw++) begin
            int szr, szt, szmax;
            mst_en = 1'b0;
            repeat (2) @(negedge clk);
            tb_page = 8'(8'h40 + sw);
            tb_base = 14'(14'h0ABC + sw * 14'h111);
            lat = sw % 3;
            szr = size_of(rxc[sw]);
            szt = size_of(txc[sw]);
            szmax = (szr > szt) ? szr : szt;
            cfg_write(2'd2, {8'h00, tb_page});
            cfg_write(2'd0, {2'b00, tb_base});
            cfg_write(2'd1, {txc[sw], rxc[sw], 8'h00});
            for (int d = 0; d < 2; d++)
                for (int k = 0; k < 64; k++) begin
                    mem[slot(d, k)]     = 32'hABC0_0000 | {20'b0, e_len(d, k, sw)};
                    mem[slot(d, k) + 1] = {e_stat(d, k), e_ptr(d, k, sw)};
                end
            acc_cnt = 0;
            mst_en = 1'b1;
            cfg_write(2'd3, 16'h0000);
            for (int k = 0; k < szmax; k++) begin
                if (k < szr) service(0, k, sw);
                if (k < szt) service(1, k, sw);
            end
            repeat (60) @(negedge clk);
            chk("R5 closed descriptor leaves rings idle", {30'b0, rx_own, tx_own}, 32'd0);
            chk("R1 both indices wrapped to 0", {16'b0, ptr_rd}, 32'd0);
            chk("R10 access count", 32'(acc_cnt), 32'(4 * (szr + szt) + 4));
            for (int d = 0; d < 2; d++) begin
                int sz;
                sz = (d == 1) ? szt : szr;
                for (int k = 0; k < sz; k++) begin
                    chk("R6 count word written", mem[slot(d, k)], {20'b0, e_dcnt(d, k, sw)});
                    chk("R6 status word written", mem[slot(d, k) + 1],
                        {(e_stat(d, k) & 8'h7F) | {1'b0, e_err(d, k, sw)}, e_ptr(d, k, sw)});
                end
                if (sz < 64)
                    chk("R1 slot past ring size untouched", mem[slot(d, sz) + 1],
                        {e_stat(d, sz), e_ptr(d, sz, sw)});
            end
            // done pulse to an idle ring
            @(negedge clk);
            rx_done = 1'b1; rx_done_cnt = 12'hFFF; rx_done_err = 7'h7F;
            @(negedge clk);
            rx_done = 1'b0;
            repeat (10) @(negedge clk);
            chk("R7 stray done: index", {16'b0, ptr_rd}, 32'd0);
            chk("R7 stray done: own", {31'b0, rx_own}, 32'd0);
            chk("R7 stray done: memory", mem[1],
                {(e_stat(0, 0) & 8'h7F) | {1'b0, e_err(0, 0, sw)}, e_ptr(0, 0, sw)});
            // re-arm slot 0 and restart with a prompt
            mem[1] = {8'h80, e_ptr(0, 0, sw)};
            cfg_write(2'd3, 16'h1234);
            wait_own(0);
            chk("R3 re-armed descriptor owned", {31'b0, rx_own}, 32'd1);
            chk("R3 re-armed length", {20'b0, rx_buf_len}, {20'b0, e_dcnt(0, 0, sw)});
            mst_en = 1'b0;
            repeat (2) @(negedge clk);
            chk("R9 disable drops ownership", {30'b0, rx_own, tx_own}, 32'd0);
            chk("R9 disable rewinds index", {16'b0, ptr_rd}, 32'd0);
            cfg_write(2'd3, 16'h0000);
            repeat (4) @(negedge clk);
            chk("R9 prompt ignored while disabled", {31'b0, mem_req}, 32'd0);
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule